// File: doc/BRIEF.md
# SHA-256 Message Schedule Finalizer

This block performs the closing step of SHA-256 message expansion for a group of four consecutive schedule words. A 128-bit partial-sum operand carries four 32-bit words, each already holding W[t-7] + σ0(W[t-15]) + W[t-16]. A 128-bit history operand carries the two most recent schedule words in its upper half. The block adds σ1 of the right earlier word to each partial sum and returns four new schedule words, packed in one 128-bit result.

The four results are not independent lanes. The upper two words take σ1 of the lower two results from the same operation, so the logic is a two-level chain. The operands enter through a valid/ready handshake. One registered stage holds the result until the consumer takes it. A new operation can be accepted in the same cycle that the previous result drains, so the block sustains one group per clock.

Top module: `sha256_sched_final`

## Requirements
- R1: Result bits 31:0 equal partial-sum bits 31:0 plus σ1(history bits 95:64). σ1(x) = ROTR17(x) ^ ROTR19(x) ^ SHR10(x).
- R2: Result bits 63:32 equal partial-sum bits 63:32 plus σ1(history bits 127:96).
- R3: Result bits 95:64 equal partial-sum bits 95:64 plus σ1 of result bits 31:0 of the same operation.
- R4: Result bits 127:96 equal partial-sum bits 127:96 plus σ1 of result bits 63:32 of the same operation.
- R5: History bits 63:0 have no effect on the result.
- R6: Every addition wraps modulo 2^32 inside its own 32-bit lane. No carry passes into a neighbouring lane.
- R7: An operation is accepted on a clock edge where in_valid and in_ready are both high. Its result is on out_data with out_valid high after that edge. out_valid falls after an edge with out_ready high and no new acceptance.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_data does not change, and offered inputs are not taken.
- R9: A synchronous active-high reset clears out_valid, and in_ready is high after reset.
- R10: in_ready is high when out_valid is low or out_ready is high. This allows back-to-back operations on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block can accept operands this cycle |
| src_psum | input | 128 | Four partial sums, lane i at bits 32i+31:32i |
| src_hist | input | 128 | Previous schedule words; only bits 127:64 are used |
| out_valid | output | 1 | Result held on out_data |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four new schedule words, lowest word in bits 31:0 |

## Verification
The block is tested first against a full 64-word schedule generated by the standard recurrence, driven group by group. A wrong lane mapping or a broken chain dependency makes this test disagree with a real expansion. Random operand pairs are then compared with the direct lane formula. Lanes filled with 0xFFFFFFFF force wraparound and expose any carry that crosses a lane. Two history operands that differ only in the ignored low half must give the same result. Stalls and back-to-back runs on the handshake show that a held result does not change and that throughput is one group per clock.

// File: rtl/sha256_sched_pkg.sv
package sha256_sched_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int ROT_A  = 17;
  localparam int ROT_B  = 19;
  localparam int SHR_C  = 10;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ssf_sigma1.sv
module ssf_sigma1 #(
  parameter int W  = 32,
  parameter int RA = 17,
  parameter int RB = 19,
  parameter int SC = 10
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] rot_a, rot_b, shr_c;

  always_comb begin
    rot_a = (x >> RA) | (x << (W - RA));
    rot_b = (x >> RB) | (x << (W - RB));
    shr_c = x >> SC;
    y     = rot_a ^ rot_b ^ shr_c;
  end
endmodule

// File: rtl/ssf_datapath.sv
module ssf_datapath #(
  parameter int W  = 32,
  parameter int RA = 17,
  parameter int RB = 19,
  parameter int SC = 10,
  localparam int LANES = 4,
  localparam int HALF  = LANES / 2,
  localparam int DW    = LANES * W
) (
  input  logic [DW-1:0] psum,
  input  logic [DW-1:0] hist,
  output logic [DW-1:0] res
);
  logic [W-1:0] lo_word [HALF];
  logic [W-1:0] hi_word [HALF];
  logic [W-1:0] lo_sig  [HALF];
  logic [W-1:0] hi_sig  [HALF];

  // first level: fed from the upper half of the history operand
  for (genvar g = 0; g < HALF; g++) begin : g_lo
    ssf_sigma1 #(.W(W), .RA(RA), .RB(RB), .SC(SC)) u_sig (
      .x (hist[(g + HALF) * W +: W]),
      .y (lo_sig[g])
    );
    assign lo_word[g] = psum[g * W +: W] + lo_sig[g];
  end

  // second level: chained on the first-level results
  for (genvar g = 0; g < HALF; g++) begin : g_hi
    ssf_sigma1 #(.W(W), .RA(RA), .RB(RB), .SC(SC)) u_sig (
      .x (lo_word[g]),
      .y (hi_sig[g])
    );
    assign hi_word[g] = psum[(g + HALF) * W +: W] + hi_sig[g];
  end

  for (genvar g = 0; g < HALF; g++) begin : g_pack
    assign res[g * W +: W]          = lo_word[g];
    assign res[(g + HALF) * W +: W] = hi_word[g];
  end
endmodule

// File: rtl/ssf_outreg.sv
module ssf_outreg #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/sha256_sched_final.sv
module sha256_sched_final
  import sha256_sched_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  parameter int ROT_A_P  = ROT_A,
  parameter int ROT_B_P  = ROT_B,
  parameter int SHR_C_P  = SHR_C,
  localparam int DW      = LANES * WORD_W_P
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] src_psum,
  input  logic [DW-1:0] src_hist,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic [DW-1:0] next_words;

  ssf_datapath #(
    .W  (WORD_W_P),
    .RA (ROT_A_P),
    .RB (ROT_B_P),
    .SC (SHR_C_P)
  ) u_dp (
    .psum (src_psum),
    .hist (src_hist),
    .res  (next_words)
  );

  ssf_outreg #(.DW(DW)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (next_words),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [4*W-1:0] src_psum,
  input logic [4*W-1:0] src_hist,
  input logic           out_valid,
  input logic           out_ready,
  input logic [4*W-1:0] out_data
);
  function automatic logic [W-1:0] s1(input logic [W-1:0] x);
    return ((x >> 17) | (x << (W - 17))) ^ ((x >> 19) | (x << (W - 19))) ^ (x >> 10);
  endfunction

  AST_LANE0_FORMULA: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_data[W-1:0] == $past(src_psum[W-1:0]) + s1($past(src_hist[3*W-1:2*W]))); // R1
  AST_LANE1_FORMULA: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_data[2*W-1:W] == $past(src_psum[2*W-1:W]) + s1($past(src_hist[4*W-1:3*W]))); // R2
  AST_LANE2_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_data[3*W-1:2*W] == $past(src_psum[3*W-1:2*W]) + s1(out_data[W-1:0])); // R3
  AST_LANE3_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_data[4*W-1:3*W] == $past(src_psum[4*W-1:3*W]) + s1(out_data[2*W-1:W])); // R4
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R7
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

bind sha256_sched_final ssf_checker #(.W(WORD_W_P)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .src_psum  (src_psum),
  .src_hist  (src_hist),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sha256_sched_final_bench.sv
`timescale 1ns/1ps
module sha256_sched_final_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src_psum = '0;
  logic [127:0] src_hist = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sha256_sched_final u_sha256_sched_final (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .src_psum  (src_psum),
    .src_hist  (src_hist),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] sg1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
  function automatic logic [31:0] sg0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b);
    logic [31:0] w16, w17, w18, w19;
    w16 = a[31:0]   + sg1(b[95:64]);
    w17 = a[63:32]  + sg1(b[127:96]);
    w18 = a[95:64]  + sg1(w16);
    w19 = a[127:96] + sg1(w17);
    return {w19, w18, w17, w16};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation with out_ready high; result checked one edge later
  task automatic run_op(input logic [127:0] a, input logic [127:0] b, output logic [127:0] r);
    @(negedge clk);
    src_psum = a; src_hist = b; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid", {127'd0, out_valid}, 128'd1);
    r = out_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] r, r2, a, b;
    logic [31:0]  w [64];
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9: reset state
    check("R9 out_valid", {127'd0, out_valid}, 128'd0);
    check("R9 in_ready", {127'd0, in_ready}, 128'd1);

    // zero history: sigma1(0)=0, chain adds sigma1 of the psum lanes
    a = {32'd4, 32'd3, 32'd2, 32'd1};
    run_op(a, '0, r);
    check("R1 zero hist", {96'd0, r[31:0]}, {96'd0, 32'd1});
    check("R3 chain from lane0", {96'd0, r[95:64]}, {96'd0, 32'd3 + sg1(32'd1)});

    // R6: wraparound inside each lane
    a = {4{32'hFFFF_FFFF}};
    b = {32'h8000_0001, 32'h0001_0000, 64'd0};
    run_op(a, b, r);
    r2 = model(a, b);
    for (int i = 0; i < 4; i++)
      check("R6 lane wrap", {96'd0, r[i*32 +: 32]}, {96'd0, r2[i*32 +: 32]});

    // R5: low half of history ignored
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    run_op(a, b, r);
    b[63:0] = ~b[63:0];
    run_op(a, b, r2);
    check("R5 ignore hist low", r2, r);

    // full schedule recurrence, group by group (R1-R4 lanes)
    for (int i = 0; i < 16; i++) w[i] = $urandom;
    for (int t = 16; t < 64; t++) w[t] = sg1(w[t-2]) + w[t-7] + sg0(w[t-15]) + w[t-16];
    for (int t = 16; t < 64; t += 4) begin
      for (int k = 0; k < 4; k++)
        a[k*32 +: 32] = w[t+k-7] + sg0(w[t+k-15]) + w[t+k-16];
      b = {w[t-1], w[t-2], $urandom, $urandom};
      run_op(a, b, r);
      check("R1 sched W16", {96'd0, r[31:0]},   {96'd0, w[t]});
      check("R2 sched W17", {96'd0, r[63:32]},  {96'd0, w[t+1]});
      check("R3 sched W18", {96'd0, r[95:64]},  {96'd0, w[t+2]});
      check("R4 sched W19", {96'd0, r[127:96]}, {96'd0, w[t+3]});
    end

    // random operands against direct formula
    for (int n = 0; n < 40; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      run_op(a, b, r);
      check("R1 R2 R3 R4 random", r, model(a, b));
    end

    // R8: back-pressure holds result, blocks new input
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    src_psum = a; src_hist = b; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    src_psum = ~a; src_hist = ~b;
    check("R8 in_ready low", {127'd0, in_ready}, 128'd0);
    repeat (3) @(negedge clk);
    check("R8 held valid", {127'd0, out_valid}, 128'd1);
    check("R8 held data", out_data, model(a, b));
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R7 drain", {127'd0, out_valid}, 128'd0);

    // R10: back-to-back with ready high
    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    src_psum = a; src_hist = b; in_valid = 1'b1;
    @(negedge clk);
    check("R10 first", out_data, model(a, b));
    check("R10 ready while full", {127'd0, in_ready}, 128'd1);
    src_psum = b; src_hist = a;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second", out_data, model(b, a));
    check("R10 still valid", {127'd0, out_valid}, 128'd1);

    // R9: reset while holding a result
    out_ready = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 reset clears", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule